// File: doc/BRIEF.md
# Speculative Indirect-Branch Path History

This block keeps a short, age-ordered record of the indirect branches a front end has predicted. A prediction target cache uses it to build its set-index hash. Each predicted indirect branch, hit or miss, is appended with its branch address, its predicted target and its instruction sequence number. The newest targets are presented every cycle so that the hash can fold them in, and speculative entries count the same as committed ones.

The record follows the pipeline through sequence numbers. A squash with a sequence number removes every younger entry. A commit walks a head index forward one entry at a time. Once a fixed number of committed entries sit behind that index, each further commit drops the oldest entry instead, so the hash always has that many committed targets to work with. When a branch is found to have gone somewhere else, its newest entry can have its target rewritten. A second output view skips the newest entry, for computing the set index of the branch that is being corrected. The buffer has a fixed capacity and raises a full flag so that the front end can stall rather than lose an entry.

Top module: `ind_path_hist`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the buffer is empty: `full` is 0, every bit of `path_vld` and `prior_vld` is 0, and every target output and `newest_pc` is zero.
- R2: A push that is accepted is seen after the next rising edge. Slot 0 of `path_tgt` then holds the pushed target, slot k holds the k-th older entry, and `newest_pc` holds the pushed branch address. Slots with no entry read zero, with their valid bit low.
- R3: A squash with sequence S removes every entry whose sequence number is greater than S and keeps all the others. A squash with S at or above every stored number changes nothing.
- R4: A commit with sequence C acts only when an entry exists at the head index and its sequence number is no greater than C. A single commit moves by at most one entry. A commit on an empty buffer does nothing.
- R5: Each eligible commit advances the head index until PATH_N entries are committed. After that, each eligible commit removes the oldest entry and leaves the head index unchanged.
- R6: A target correction replaces the target of the newest entry and leaves its branch address, its sequence number and all other entries untouched.
- R7: Slot k of `prior_tgt` and `prior_vld` shows the entry k+1 positions older than the newest, that is, the path seen with the newest entry left out.
- R8: `full` is high exactly when DEPTH entries are stored. A push while `full` is high is ignored.
- R9: When squash and commit are both asserted in one cycle, the squash is applied first and the commit is judged on the surviving entries. A push in any cycle with a squash is ignored.
- R10: A correction is ignored when the buffer is empty, and also in any cycle that carries a push or a squash.
- R11: Sequence numbers are compared as unsigned SEQ_W-bit values. Pushes must arrive in increasing sequence order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Append a predicted indirect branch |
| push_pc | input | PC_W | Branch address of the pushed entry |
| push_tgt | input | PC_W | Predicted target of the pushed entry |
| push_seq | input | SEQ_W | Sequence number of the pushed entry |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| cm_vld | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| fix_vld | input | 1 | Rewrite the newest entry's target |
| fix_tgt | input | PC_W | Corrected target |
| path_tgt | output | PATH_N x PC_W | Newest targets, slot 0 newest |
| path_vld | output | PATH_N | Valid bit per `path_tgt` slot |
| prior_tgt | output | PATH_N x PC_W | Targets with the newest entry skipped |
| prior_vld | output | PATH_N | Valid bit per `prior_tgt` slot |
| newest_pc | output | PC_W | Branch address of the newest entry, zero when empty |
| full | output | 1 | Buffer holds DEPTH entries |

## Verification
A wrong occupancy count or read pointer shows at once: it moves every `path_tgt` slot on the cycle after the operation that corrupted it. A head index that is off by one shows only later, either when a commit drops an entry too early or too late, or when a commit fails to act. That effect reaches the ports through `full` on a buffer filled to capacity, so the commit window is tested with the buffer full and a push follows each commit. A squash that keeps the wrong entries, or a misplaced correction write, changes `path_tgt`, `prior_tgt` or `newest_pc` on the very next cycle.

// File: rtl/iph_pkg.sv
package iph_pkg;

  // What the single storage write port does in a given cycle.
  typedef enum logic [1:0] {
    HOP_IDLE = 2'd0,
    HOP_PUSH = 2'd1,
    HOP_FIX  = 2'd2
  } hist_op_e;

endpackage

// File: rtl/iph_store.sv
// Entry storage: one write port that either writes a whole entry or only its
// target field. Data is not reset; the controller's count tells which entries
// are valid.
module iph_store
  import iph_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  hist_op_e                     op,
  input  logic [PTR_W-1:0]             slot,
  input  logic [PC_W-1:0]              wr_pc,
  input  logic [PC_W-1:0]              wr_tgt,
  input  logic [SEQ_W-1:0]             wr_seq,
  output logic [DEPTH-1:0][PC_W-1:0]   pc_q,
  output logic [DEPTH-1:0][PC_W-1:0]   tgt_q,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seq_q
);

  logic [PC_W-1:0]  pc_mem  [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  logic [SEQ_W-1:0] seq_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (op == HOP_PUSH) begin
      pc_mem[slot]  <= wr_pc;
      tgt_mem[slot] <= wr_tgt;
      seq_mem[slot] <= wr_seq;
    end else if (op == HOP_FIX) begin
      tgt_mem[slot] <= wr_tgt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rd
    assign pc_q[g]  = pc_mem[g];
    assign tgt_q[g] = tgt_mem[g];
    assign seq_q[g] = seq_mem[g];
  end

endmodule

// File: rtl/iph_ctl.sv
// Ordering control: read pointer, occupancy, committed-head index, full flag,
// and the choice of write operation.
module iph_ctl
  import iph_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int PATH_N = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HID_W = $clog2(PATH_N + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_vld,
  input  logic                         sq_vld,
  input  logic [SEQ_W-1:0]             sq_seq,
  input  logic                         cm_vld,
  input  logic [SEQ_W-1:0]             cm_seq,
  input  logic                         fix_vld,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q,
  output logic [PTR_W-1:0]             rd_q,
  output logic [CNT_W-1:0]             cnt_q,
  output logic [HID_W-1:0]             hid_q,
  output logic                         full_q,
  output hist_op_e                     op,
  output logic [PTR_W-1:0]             op_slot
);

  function automatic logic [PTR_W-1:0] slot_at(input logic [PTR_W-1:0] base,
                                               input int off);
    logic [31:0] sum;
    sum = 32'(base) + 32'(off);
    return sum[PTR_W-1:0];
  endfunction

  int               surv;
  int               cnt_s;
  int               hid_s;
  int               cnt_n;
  int               hid_n;
  logic [PTR_W-1:0] rd_n;
  logic [SEQ_W-1:0] head_seq;
  logic             cm_ok;
  logic             push_ok;
  logic             fix_ok;

  // Survivors of a squash: entries are in increasing sequence order, so the
  // survivors are exactly the oldest 'surv' entries.
  always_comb begin
    surv = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_q) && seq_q[slot_at(rd_q, i)] <= sq_seq) begin
        surv = surv + 1;
      end
    end
  end

  always_comb begin
    cnt_s    = sq_vld ? surv : int'(cnt_q);
    hid_s    = (int'(hid_q) > cnt_s) ? cnt_s : int'(hid_q);
    head_seq = seq_q[slot_at(rd_q, hid_s)];
    cm_ok    = cm_vld && (hid_s < cnt_s) && (head_seq <= cm_seq);
    push_ok  = push_vld && !sq_vld && !full_q;
    fix_ok   = fix_vld && !sq_vld && !push_vld && (cnt_q != '0);

    rd_n  = rd_q;
    cnt_n = cnt_s;
    hid_n = hid_s;
    if (cm_ok) begin
      if (hid_s == PATH_N) begin
        rd_n  = slot_at(rd_q, 1);
        cnt_n = cnt_s - 1;
      end else begin
        hid_n = hid_s + 1;
      end
    end
    if (push_ok) begin
      cnt_n = cnt_n + 1;
    end

    if (push_ok) begin
      op      = HOP_PUSH;
      op_slot = slot_at(rd_q, int'(cnt_q));
    end else if (fix_ok) begin
      op      = HOP_FIX;
      op_slot = slot_at(rd_q, int'(cnt_q) - 1);
    end else begin
      op      = HOP_IDLE;
      op_slot = rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      hid_q  <= '0;
      full_q <= 1'b0;
    end else begin
      rd_q   <= rd_n;
      cnt_q  <= CNT_W'(cnt_n);
      hid_q  <= HID_W'(hid_n);
      full_q <= (cnt_n == DEPTH);
    end
  end

endmodule

// File: rtl/iph_path_sel.sv
// Picks PATH_N targets counting back from the newest entry, optionally
// skipping the newest SKIP entries. Missing positions read zero.
module iph_path_sel #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int PATH_N = 3,
  parameter int SKIP   = 0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][PC_W-1:0]   tgt_q,
  input  logic [PTR_W-1:0]             rd_q,
  input  logic [CNT_W-1:0]             cnt_q,
  output logic [PATH_N-1:0][PC_W-1:0]  sel_tgt,
  output logic [PATH_N-1:0]            sel_vld
);

  for (genvar k = 0; k < PATH_N; k++) begin : g_pos
    int          pos;
    logic [31:0] phys;
    always_comb begin
      pos  = int'(cnt_q) - 1 - SKIP - k;
      phys = 32'(rd_q) + 32'(pos);
      if (pos >= 0) begin
        sel_vld[k] = 1'b1;
        sel_tgt[k] = tgt_q[phys[PTR_W-1:0]];
      end else begin
        sel_vld[k] = 1'b0;
        sel_tgt[k] = '0;
      end
    end
  end

endmodule

// File: rtl/ind_path_hist.sv
module ind_path_hist
  import iph_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int SEQ_W  = 16,
  parameter int PATH_N = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_vld,
  input  logic [PC_W-1:0]              push_pc,
  input  logic [PC_W-1:0]              push_tgt,
  input  logic [SEQ_W-1:0]             push_seq,
  input  logic                         sq_vld,
  input  logic [SEQ_W-1:0]             sq_seq,
  input  logic                         cm_vld,
  input  logic [SEQ_W-1:0]             cm_seq,
  input  logic                         fix_vld,
  input  logic [PC_W-1:0]              fix_tgt,
  output logic [PATH_N-1:0][PC_W-1:0]  path_tgt,
  output logic [PATH_N-1:0]            path_vld,
  output logic [PATH_N-1:0][PC_W-1:0]  prior_tgt,
  output logic [PATH_N-1:0]            prior_vld,
  output logic [PC_W-1:0]              newest_pc,
  output logic                         full
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HID_W = $clog2(PATH_N + 1);

  if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 || PATH_N < 1 || PATH_N >= DEPTH)
  begin : g_bad_cfg
    initial $error("ind_path_hist: DEPTH must be a power of two above PATH_N");
  end

  logic [DEPTH-1:0][PC_W-1:0]  pc_q;
  logic [DEPTH-1:0][PC_W-1:0]  tgt_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [PTR_W-1:0]            rd_q;
  logic [CNT_W-1:0]            cnt;
  logic [HID_W-1:0]            hid;
  hist_op_e                    op;
  logic [PTR_W-1:0]            op_slot;
  logic [PC_W-1:0]             wr_tgt;
  logic [PTR_W-1:0]            newest_slot;

  iph_ctl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PATH_N(PATH_N)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .push_vld (push_vld),
    .sq_vld   (sq_vld),
    .sq_seq   (sq_seq),
    .cm_vld   (cm_vld),
    .cm_seq   (cm_seq),
    .fix_vld  (fix_vld),
    .seq_q    (seq_q),
    .rd_q     (rd_q),
    .cnt_q    (cnt),
    .hid_q    (hid),
    .full_q   (full),
    .op       (op),
    .op_slot  (op_slot)
  );

  assign wr_tgt = (op == HOP_FIX) ? fix_tgt : push_tgt;

  iph_store #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_store (
    .clk    (clk),
    .op     (op),
    .slot   (op_slot),
    .wr_pc  (push_pc),
    .wr_tgt (wr_tgt),
    .wr_seq (push_seq),
    .pc_q   (pc_q),
    .tgt_q  (tgt_q),
    .seq_q  (seq_q)
  );

  iph_path_sel #(.DEPTH(DEPTH), .PC_W(PC_W), .PATH_N(PATH_N), .SKIP(0)) u_sel_path (
    .tgt_q   (tgt_q),
    .rd_q    (rd_q),
    .cnt_q   (cnt),
    .sel_tgt (path_tgt),
    .sel_vld (path_vld)
  );

  iph_path_sel #(.DEPTH(DEPTH), .PC_W(PC_W), .PATH_N(PATH_N), .SKIP(1)) u_sel_prior (
    .tgt_q   (tgt_q),
    .rd_q    (rd_q),
    .cnt_q   (cnt),
    .sel_tgt (prior_tgt),
    .sel_vld (prior_vld)
  );

  assign newest_slot = rd_q + PTR_W'(cnt - 1'b1);
  assign newest_pc   = (cnt != '0) ? pc_q[newest_slot] : '0;

endmodule

// File: rtl/ind_path_hist_chk.sv
module ind_path_hist_chk #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int PATH_N = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HID_W = $clog2(PATH_N + 1)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         push_vld,
  input logic [PC_W-1:0]              push_tgt,
  input logic                         sq_vld,
  input logic                         cm_vld,
  input logic                         fix_vld,
  input logic [PC_W-1:0]              fix_tgt,
  input logic [PATH_N-1:0][PC_W-1:0]  path_tgt,
  input logic [PATH_N-1:0]            path_vld,
  input logic [PATH_N-1:0][PC_W-1:0]  prior_tgt,
  input logic [PATH_N-1:0]            prior_vld,
  input logic                         full,
  input logic [CNT_W-1:0]             cnt,
  input logic [HID_W-1:0]             hid
);

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !full && path_vld == '0 && prior_vld == '0));

  a_r2_push_newest: assert property (@(posedge clk) disable iff (rst)
    (push_vld && !sq_vld && !full) |=> (path_vld[0] && path_tgt[0] == $past(push_tgt)));

  a_r3_squash_shrinks: assert property (@(posedge clk) disable iff (rst)
    sq_vld |=> (cnt <= $past(cnt)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (cm_vld && !sq_vld && !push_vld) |=> (cnt == $past(cnt) || cnt + 1 == $past(cnt)));

  a_r5_head_bound: assert property (@(posedge clk) disable iff (rst)
    (hid <= PATH_N && hid <= cnt));

  a_r6_fix_lands: assert property (@(posedge clk) disable iff (rst)
    (fix_vld && !sq_vld && !push_vld && path_vld[0]) |=> (path_tgt[0] == $past(fix_tgt)));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt <= DEPTH));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && !cm_vld && !sq_vld) |=> full);

  if (PATH_N >= 2) begin : g_r7
    a_r7_prior_shift: assert property (@(posedge clk) disable iff (rst)
      path_vld[1] |-> (prior_vld[0] && prior_tgt[0] == path_tgt[1]));
  end

endmodule

bind ind_path_hist ind_path_hist_chk #(
  .DEPTH(DEPTH), .PC_W(PC_W), .PATH_N(PATH_N)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_vld  (push_vld),
  .push_tgt  (push_tgt),
  .sq_vld    (sq_vld),
  .cm_vld    (cm_vld),
  .fix_vld   (fix_vld),
  .fix_tgt   (fix_tgt),
  .path_tgt  (path_tgt),
  .path_vld  (path_vld),
  .prior_tgt (prior_tgt),
  .prior_vld (prior_vld),
  .full      (full),
  .cnt       (cnt),
  .hid       (hid)
);

// File: tb/tb_ind_path_hist.sv
module tb_ind_path_hist;

  localparam int DEPTH  = 8;
  localparam int PC_W   = 32;
  localparam int SEQ_W  = 16;
  localparam int PATH_N = 3;

  logic                         clk = 1'b0;
  logic                         rst = 1'b1;
  logic                         push_vld = 1'b0;
  logic [PC_W-1:0]              push_pc = '0;
  logic [PC_W-1:0]              push_tgt = '0;
  logic [SEQ_W-1:0]             push_seq = '0;
  logic                         sq_vld = 1'b0;
  logic [SEQ_W-1:0]             sq_seq = '0;
  logic                         cm_vld = 1'b0;
  logic [SEQ_W-1:0]             cm_seq = '0;
  logic                         fix_vld = 1'b0;
  logic [PC_W-1:0]              fix_tgt = '0;
  logic [PATH_N-1:0][PC_W-1:0]  path_tgt;
  logic [PATH_N-1:0]            path_vld;
  logic [PATH_N-1:0][PC_W-1:0]  prior_tgt;
  logic [PATH_N-1:0]            prior_vld;
  logic [PC_W-1:0]              newest_pc;
  logic                         full;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model built from the requirements.
  logic [PC_W-1:0]  m_pc  [$];
  logic [PC_W-1:0]  m_tgt [$];
  logic [SEQ_W-1:0] m_seq [$];
  int               m_hid = 0;

  always #5 clk = ~clk;

  ind_path_hist #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W), .PATH_N(PATH_N)) dut (
    .clk(clk), .rst(rst),
    .push_vld(push_vld), .push_pc(push_pc), .push_tgt(push_tgt), .push_seq(push_seq),
    .sq_vld(sq_vld), .sq_seq(sq_seq), .cm_vld(cm_vld), .cm_seq(cm_seq),
    .fix_vld(fix_vld), .fix_tgt(fix_tgt),
    .path_tgt(path_tgt), .path_vld(path_vld), .prior_tgt(prior_tgt),
    .prior_vld(prior_vld), .newest_pc(newest_pc), .full(full)
  );

  task automatic check_ports(input string tag);
    logic [PATH_N-1:0][PC_W-1:0] et, ep;
    logic [PATH_N-1:0]           ev, epv;
    logic [PC_W-1:0]             en;
    int n;
    n = m_tgt.size();
    for (int k = 0; k < PATH_N; k++) begin
      ev[k]  = (k < n);
      et[k]  = (k < n) ? m_tgt[n-1-k] : '0;
      epv[k] = (k + 1 < n);
      ep[k]  = (k + 1 < n) ? m_tgt[n-2-k] : '0;
    end
    en = (n > 0) ? m_pc[n-1] : '0;
    checks++;
    if (path_tgt !== et || path_vld !== ev || newest_pc !== en) begin
      errors++;
      $display("FAIL %s path: got tgt=%h vld=%b pc=%h exp tgt=%h vld=%b pc=%h",
               tag, path_tgt, path_vld, newest_pc, et, ev, en);
    end
    checks++;
    if (prior_tgt !== ep || prior_vld !== epv) begin
      errors++;
      $display("FAIL %s prior: got tgt=%h vld=%b exp tgt=%h vld=%b",
               tag, prior_tgt, prior_vld, ep, epv);
    end
    checks++;
    if (full !== (n == DEPTH)) begin
      errors++;
      $display("FAIL %s full: got %b exp %b", tag, full, (n == DEPTH));
    end
  endtask

  task automatic model_apply(input bit p, input logic [PC_W-1:0] ppc, ptgt,
                             input logic [SEQ_W-1:0] pseq, input bit s,
                             input logic [SEQ_W-1:0] sseq, input bit c,
                             input logic [SEQ_W-1:0] cseq, input bit f,
                             input logic [PC_W-1:0] ftgt);
    int pre_n;
    pre_n = m_tgt.size();
    if (s) begin
      while (m_seq.size() > 0 && m_seq[m_seq.size()-1] > sseq) begin
        void'(m_pc.pop_back()); void'(m_tgt.pop_back()); void'(m_seq.pop_back());
      end
      if (m_hid > m_seq.size()) m_hid = m_seq.size();
    end
    if (c && m_hid < m_seq.size() && m_seq[m_hid] <= cseq) begin
      if (m_hid == PATH_N) begin
        void'(m_pc.pop_front()); void'(m_tgt.pop_front()); void'(m_seq.pop_front());
      end else begin
        m_hid++;
      end
    end
    if (p && !s && pre_n < DEPTH) begin
      m_pc.push_back(ppc); m_tgt.push_back(ptgt); m_seq.push_back(pseq);
    end
    if (f && !s && !p && pre_n > 0) m_tgt[m_tgt.size()-1] = ftgt;
  endtask

  // Drive one cycle of stimulus (called at a falling edge), then check.
  task automatic step(input bit p, input logic [PC_W-1:0] ppc, ptgt,
                      input logic [SEQ_W-1:0] pseq, input bit s,
                      input logic [SEQ_W-1:0] sseq, input bit c,
                      input logic [SEQ_W-1:0] cseq, input bit f,
                      input logic [PC_W-1:0] ftgt, input string tag);
    push_vld = p; push_pc = ppc; push_tgt = ptgt; push_seq = pseq;
    sq_vld = s; sq_seq = sseq; cm_vld = c; cm_seq = cseq;
    fix_vld = f; fix_tgt = ftgt;
    @(posedge clk);
    model_apply(p, ppc, ptgt, pseq, s, sseq, c, cseq, f, ftgt);
    @(negedge clk);
    push_vld = 0; sq_vld = 0; cm_vld = 0; fix_vld = 0;
    check_ports(tag);
  endtask

  task automatic do_push(input int seq, input string tag);
    step(1, 32'h1000 + 32'(seq) * 4, 32'hA000_0000 + 32'(seq) * 32'h10,
         SEQ_W'(seq), 0, '0, 0, '0, 0, '0, tag);
  endtask

  task automatic do_squash(input int seq, input string tag);
    step(0, '0, '0, '0, 1, SEQ_W'(seq), 0, '0, 0, '0, tag);
  endtask

  task automatic do_commit(input int seq, input string tag);
    step(0, '0, '0, '0, 0, '0, 1, SEQ_W'(seq), 0, '0, tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1;
    m_pc.delete(); m_tgt.delete(); m_seq.delete(); m_hid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_ports(tag);
    rst = 0;
    @(negedge clk);
    check_ports(tag);
  endtask

  task automatic t_reset();
    do_reset("R1 reset state");
  endtask

  task automatic t_fill();
    do_reset("R1 reset before fill");
    for (int i = 1; i <= DEPTH; i++) do_push(i, "R2 push order");
    do_push(40, "R8 push while full ignored");
  endtask

  task automatic t_commit_window();
    do_commit(0, "R4 commit older than head ignored");
    do_commit(1, "R5 head advance 1");
    do_commit(2, "R5 head advance 2");
    do_commit(3, "R5 head advance 3 keeps entries");
    do_commit(4, "R5 pop oldest after window filled");
    do_commit(4, "R4 head entry younger than commit");
    do_push(9, "R8 refill to full");
    do_commit(50, "R4 one entry per commit");
    do_push(10, "R4 single pop leaves room for one");
    do_push(11, "R8 push while full ignored again");
  endtask

  task automatic t_squash();
    do_squash(8, "R3 squash trims younger");
    do_squash(100, "R3 squash above all keeps all");
    do_squash(6, "R3 squash to committed edge");
  endtask

  task automatic t_fix();
    step(0, '0, '0, '0, 0, '0, 0, '0, 1, 32'hBEEF_0000, "R6 correct newest target");
    check_ports("R7 prior skips corrected entry");
    step(1, 32'h2222, 32'hC0DE_0000, 16'd20, 0, '0, 0, '0, 1, 32'hDEAD_0000,
         "R10 correction with push ignored");
    step(0, '0, '0, '0, 1, 16'd100, 0, '0, 1, 32'hFACE_0000,
         "R10 correction with squash ignored");
  endtask

  task automatic t_combined();
    do_reset("R1 reset before combo");
    for (int i = 1; i <= 6; i++) do_push(i, "R2 push for combo");
    do_commit(1, "R5 combo head 1");
    do_commit(2, "R5 combo head 2");
    step(1, 32'h3333, 32'hAAAA_0000, 16'd7, 1, 16'd3, 1, 16'd3, 0, '0,
         "R9 squash then commit, push ignored");
    step(1, 32'h4444, 32'hBBBB_0000, 16'd8, 0, '0, 1, 16'd8, 0, '0,
         "R9 push with commit accepted");
  endtask

  task automatic t_empty();
    do_reset("R1 reset before empty tests");
    step(0, '0, '0, '0, 0, '0, 0, '0, 1, 32'h1234_5678, "R10 correction on empty");
    do_commit(100, "R4 commit on empty");
    do_squash(0, "R3 squash on empty");
  endtask

  task automatic t_unsigned();
    do_reset("R1 reset before unsigned");
    do_push(16'h7FFE, "R11 push below midpoint");
    do_push(16'h7FFF, "R11 push at midpoint");
    do_push(16'h8000, "R11 push above midpoint");
    do_push(16'h8001, "R11 push above midpoint 2");
    do_squash(16'h7FFF, "R11 squash compares unsigned");
    do_commit(16'h8000, "R11 commit compares unsigned");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_commit_window();
    t_squash();
    t_fix();
    t_combined();
    t_empty();
    t_unsigned();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule